// File: doc/BRIEF.md
# Read Data Parity Status Generator

This block watches the data bus of a processor bus interface and, when a read transfer completes, checks each byte lane against its parity bit. The verdict comes out on an active-low status pin one clock later: low means at least one checked lane held a parity error, high means no error or no read completed. The pin carries its own output-enable so that a board-level test mode can release it.

Only lanes that take part in the transfer are judged. The active-low byte enables select lanes, and the two active-low bus-size inputs narrow that selection further: the byte-wide size keeps only the lowest lane and the halfword size keeps the two lowest lanes. Either of the two ready inputs ends a transfer. Write transfers and idle clocks always leave the status high.

Top module: `rd_parity_status`

## Requirements
- R1: While `rst` is high and in the first clock after it falls, `perr_n_o` is high.
- R2: The status for a read that ends at a rising edge (a ready input low at that edge) is driven right after that edge and held for exactly one clock; after the next edge it is high again unless another read ends there.
- R3: A lane is in error when its 8 data bits (`dat_i[8*k+7:8*k]` for lane k) together with `par_i[k]` contain an odd number of ones (even parity); a completed read with any checked lane in error drives `perr_n_o` low.
- R4: A lane whose `be_n_i[k]` is high is never checked, whatever its data and parity.
- R5: When `bs8_n_i` is low, only lane 0 is checked; this takes priority over `bs16_n_i`.
- R6: When `bs16_n_i` is low and `bs8_n_i` is high, only lanes 0 and 1 are checked.
- R7: A transfer with `wr_i` high (write) never drives `perr_n_o` low.
- R8: A read ends when `rdy_n_i` or `brdy_n_i` is low, each alone being enough; when both are high, `perr_n_o` is high on the following clock.
- R9: `perr_oe_o` is low exactly while `tri_test_i` is high and high otherwise, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dat_i | input | 32 | Data bus, four byte lanes |
| par_i | input | 4 | One parity bit per byte lane |
| be_n_i | input | 4 | Byte enables, active low |
| bs8_n_i | input | 1 | Byte-wide bus size, active low |
| bs16_n_i | input | 1 | Halfword bus size, active low |
| wr_i | input | 1 | High for write, low for read |
| rdy_n_i | input | 1 | Single-transfer ready, active low |
| brdy_n_i | input | 1 | Burst ready, active low |
| tri_test_i | input | 1 | Three-state test mode, active high |
| perr_n_o | output | 1 | Parity status, low on error |
| perr_oe_o | output | 1 | Output enable for the status pin |

## Verification
The status is due one clock after the edge at which ready is seen, so the bench drives each transfer on a falling edge and compares the status at the next falling edge, after exactly one register has updated; it then clears ready and expects high one falling edge later to confirm the one-clock width. The output-enable has no register, so it is compared on the same falling edge at which test mode was driven. Random cycles carry the previous cycle's expected status forward and compare it one clock after the inputs that produced it.

// File: rtl/rps_pkg.sv
package rps_pkg;

   typedef enum logic [1:0] {
      BUS_FULL = 2'd0,
      BUS_HALF = 2'd1,
      BUS_BYTE = 2'd2
   } bus_width_e;

   // number of lanes a given bus width places on the low end of the bus
   function automatic int lanes_for(bus_width_e w, int full_l, int half_l, int byte_l);
      case (w)
         BUS_BYTE: lanes_for = byte_l;
         BUS_HALF: lanes_for = half_l;
         default:  lanes_for = full_l;
      endcase
   endfunction

endpackage

// File: rtl/rps_width_decode.sv
module rps_width_decode
   import rps_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int HALF_LANES = 2,
   parameter int BYTE_LANES = 1
) (
   input  logic             bs8_n,
   input  logic             bs16_n,
   input  logic [LANES-1:0] be_n,
   output logic [LANES-1:0] lane_en
);

   bus_width_e       width;
   logic [LANES-1:0] size_ok;

   // narrow size wins over halfword
   always_comb begin
      if (!bs8_n)       width = BUS_BYTE;
      else if (!bs16_n) width = BUS_HALF;
      else              width = BUS_FULL;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign size_ok[i] = (i < lanes_for(width, LANES, HALF_LANES, BYTE_LANES));
   end

   assign lane_en = size_ok & ~be_n;

endmodule

// File: rtl/rps_lane_check.sv
module rps_lane_check #(
   parameter int LANE_W     = 8,
   parameter bit ODD_PARITY = 1'b0
) (
   input  logic [LANE_W-1:0] data,
   input  logic              par,
   output logic              err
);

   logic ones_odd;

   assign ones_odd = ^{data, par};

   if (ODD_PARITY) begin : g_odd
      assign err = ~ones_odd;
   end else begin : g_even
      assign err = ones_odd;
   end

endmodule

// File: rtl/rps_status_reg.sv
module rps_status_reg #(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rd_done,
   input  logic [LANES-1:0] lane_err,
   input  logic [LANES-1:0] lane_en,
   output logic             status_n
);

   logic any_err;

   assign any_err = |(lane_err & lane_en);

   always_ff @(posedge clk) begin
      if (rst) status_n <= 1'b1;
      else     status_n <= ~(rd_done & any_err);
   end

endmodule

// File: rtl/rd_parity_status.sv
module rd_parity_status
   import rps_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int LANE_W     = 8,
   parameter int HALF_W     = 16,
   parameter int BYTE_W     = 8,
   parameter bit ODD_PARITY = 1'b0,
   localparam int LANES      = DATA_W / LANE_W,
   localparam int HALF_LANES = HALF_W / LANE_W,
   localparam int BYTE_LANES = BYTE_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] dat_i,
   input  logic [LANES-1:0]  par_i,
   input  logic [LANES-1:0]  be_n_i,
   input  logic              bs8_n_i,
   input  logic              bs16_n_i,
   input  logic              wr_i,
   input  logic              rdy_n_i,
   input  logic              brdy_n_i,
   input  logic              tri_test_i,
   output logic              perr_n_o,
   output logic              perr_oe_o
);

   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a multiple of LANE_W");
   end
   if (BYTE_W > HALF_W || HALF_W > DATA_W) begin : g_bad_size
      $error("bus sizes must satisfy BYTE_W <= HALF_W <= DATA_W");
   end
   if (BYTE_LANES < 1) begin : g_bad_byte
      $error("BYTE_W must hold at least one lane");
   end

   logic [LANES-1:0] lane_en;
   logic [LANES-1:0] lane_err;
   logic             rd_done;

   rps_width_decode #(
      .LANES(LANES), .HALF_LANES(HALF_LANES), .BYTE_LANES(BYTE_LANES)
   ) u_wdec (
      .bs8_n(bs8_n_i), .bs16_n(bs16_n_i), .be_n(be_n_i), .lane_en(lane_en)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_chk
      rps_lane_check #(.LANE_W(LANE_W), .ODD_PARITY(ODD_PARITY)) u_lane (
         .data(dat_i[k*LANE_W +: LANE_W]),
         .par (par_i[k]),
         .err (lane_err[k])
      );
   end

   assign rd_done = ~wr_i & ~(rdy_n_i & brdy_n_i);

   rps_status_reg #(.LANES(LANES)) u_stat (
      .clk(clk), .rst(rst), .rd_done(rd_done),
      .lane_err(lane_err), .lane_en(lane_en), .status_n(perr_n_o)
   );

   assign perr_oe_o = ~tri_test_i;

endmodule

// File: rtl/rd_parity_status_chk.sv
module rd_parity_status_chk #(
   parameter int LANE_W     = 8,
   parameter bit ODD_PARITY = 1'b0
) (
   input logic              clk,
   input logic              rst,
   input logic [LANE_W-1:0] lane0_d,
   input logic              lane0_p,
   input logic              be0_n,
   input logic              bs8_n,
   input logic              wr,
   input logic              rdy_n,
   input logic              brdy_n,
   input logic              tri_test,
   input logic              perr_n,
   input logic              perr_oe
);

   logic bad0;
   assign bad0 = (^{lane0_d, lane0_p}) ^ ODD_PARITY;

   // R1
   rst_release_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> perr_n);

   // R7
   write_high_chk: assert property (@(posedge clk) disable iff (rst)
      $past(wr) |-> perr_n);

   // R8
   idle_high_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rdy_n & brdy_n) |-> perr_n);

   // R3
   lane0_err_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!wr && !(rdy_n && brdy_n) && !be0_n && bad0) |-> !perr_n);

   // R5
   byte_mode_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!bs8_n && !bad0) |-> perr_n);

   // R9
   float_chk: assert property (@(posedge clk) disable iff (rst)
      tri_test |-> !perr_oe);

   // R9
   drive_chk: assert property (@(posedge clk) disable iff (rst)
      !tri_test |-> perr_oe);

endmodule

bind rd_parity_status rd_parity_status_chk #(
   .LANE_W(LANE_W), .ODD_PARITY(ODD_PARITY)
) u_chk (
   .clk(clk), .rst(rst),
   .lane0_d(dat_i[LANE_W-1:0]), .lane0_p(par_i[0]), .be0_n(be_n_i[0]),
   .bs8_n(bs8_n_i), .wr(wr_i), .rdy_n(rdy_n_i), .brdy_n(brdy_n_i),
   .tri_test(tri_test_i), .perr_n(perr_n_o), .perr_oe(perr_oe_o)
);

// File: tb/sim_rd_parity_status.sv
module sim_rd_parity_status;

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] dat;
   logic [3:0]  par, be_n;
   logic        bs8_n, bs16_n, wr, rdy_n, brdy_n, tri_t;
   logic        perr_n, perr_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rd_parity_status u0 (
      .clk(clk), .rst(rst), .dat_i(dat), .par_i(par), .be_n_i(be_n),
      .bs8_n_i(bs8_n), .bs16_n_i(bs16_n), .wr_i(wr), .rdy_n_i(rdy_n),
      .brdy_n_i(brdy_n), .tri_test_i(tri_t), .perr_n_o(perr_n), .perr_oe_o(perr_oe)
   );

   function automatic logic [3:0] gpar(input logic [31:0] d);
      logic [3:0] p;
      for (int k = 0; k < 4; k++) p[k] = ^d[8*k +: 8];
      return p;
   endfunction

   function automatic logic model(input logic [31:0] d, input logic [3:0] p, input logic [3:0] bn,
                                  input logic b8, input logic b16, input logic w,
                                  input logic r, input logic br);
      logic [3:0] m;
      m = ~bn;
      if (!b8)       m &= 4'b0001;
      else if (!b16) m &= 4'b0011;
      if (w || (r && br)) return 1'b1;
      for (int k = 0; k < 4; k++)
         if (m[k] && (^{d[8*k +: 8], p[k]})) return 1'b0;
      return 1'b1;
   endfunction

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic idle();
      wr = 1'b0; rdy_n = 1'b1; brdy_n = 1'b1;
   endtask

   // drive one transfer, check its status one clock later, then the return to high
   task automatic xfer(input logic [31:0] d, input logic [3:0] flip, input logic [3:0] bn,
                       input logic b8, input logic b16, input logic w,
                       input logic r, input logic br, input string tag);
      logic e;
      @(negedge clk);
      dat = d; par = gpar(d) ^ flip; be_n = bn; bs8_n = b8; bs16_n = b16;
      wr = w; rdy_n = r; brdy_n = br;
      e = model(d, gpar(d) ^ flip, bn, b8, b16, w, r, br);
      @(negedge clk);
      check(perr_n, e, tag);
      idle();
      @(negedge clk);
      check(perr_n, 1'b1, "R2 one-clock width");
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic exp_q;
      void'($urandom(32'd4242));
      rst = 1'b1; dat = '0; par = '0; be_n = 4'hF; bs8_n = 1'b1; bs16_n = 1'b1;
      tri_t = 1'b0; idle();
      repeat (3) @(negedge clk);
      check(perr_n, 1'b1, "R1 in reset");
      rst = 1'b0;
      @(negedge clk);
      check(perr_n, 1'b1, "R1 after reset");
      check(perr_oe, 1'b1, "R9 driven");

      // R2, R3: error in lane 2, full width
      xfer(32'h1234_5678, 4'b0100, 4'b0000, 1, 1, 0, 0, 1, "R2 R3 lane2 error");
      xfer(32'hA5A5_0F0F, 4'b0000, 4'b0000, 1, 1, 0, 0, 1, "R3 clean data");
      xfer(32'hFFFF_FFFF, 4'b1000, 4'b0000, 1, 1, 0, 1, 0, "R3 R8 burst ready lane3");
      // R4: error only in disabled lane
      xfer(32'h0101_0101, 4'b0010, 4'b1010, 1, 1, 0, 0, 1, "R4 disabled lane1");
      xfer(32'h0101_0101, 4'b0010, 4'b1000, 1, 1, 0, 0, 1, "R4 enabled lane1");
      // R5: byte-wide
      xfer(32'h00FF_00FF, 4'b0010, 4'b0000, 0, 1, 0, 0, 1, "R5 lane1 ignored");
      xfer(32'h00FF_00FF, 4'b0001, 4'b0000, 0, 1, 0, 0, 1, "R5 lane0 error");
      xfer(32'h00FF_00FF, 4'b0010, 4'b0000, 0, 0, 0, 0, 1, "R5 priority over halfword");
      // R6: halfword
      xfer(32'h3C3C_3C3C, 4'b0010, 4'b0000, 1, 0, 0, 0, 1, "R6 lane1 error");
      xfer(32'h3C3C_3C3C, 4'b0100, 4'b0000, 1, 0, 0, 0, 1, "R6 lane2 ignored");
      // R7: write with bad parity
      xfer(32'h8000_0001, 4'b1111, 4'b0000, 1, 1, 1, 0, 0, "R7 write");
      // R8: no ready
      xfer(32'h8000_0001, 4'b1111, 4'b0000, 1, 1, 0, 1, 1, "R8 no ready");
      // R9
      @(negedge clk); tri_t = 1'b1;
      #1 check(perr_oe, 1'b0, "R9 floated");
      @(negedge clk); tri_t = 1'b0;
      #1 check(perr_oe, 1'b1, "R9 released");

      // random traffic, expected status carried one clock
      exp_q = 1'b1;
      for (int n = 0; n < 600; n++) begin
         logic [3:0] fl;
         @(negedge clk);
         check(perr_n, exp_q, "R3 random");
         check(perr_oe, ~tri_t, "R9 random");
         dat    = $urandom;
         fl     = ($urandom % 3 == 0) ? 4'($urandom) : 4'b0000;
         par    = gpar(dat) ^ fl;
         be_n   = 4'($urandom);
         bs8_n  = ($urandom % 4) != 0;
         bs16_n = ($urandom % 3) != 0;
         wr     = ($urandom % 4) == 0;
         rdy_n  = 1'($urandom);
         brdy_n = 1'($urandom);
         tri_t  = ($urandom % 8) == 0;
         exp_q  = model(dat, par, be_n, bs8_n, bs16_n, wr, rdy_n, brdy_n);
      end
      @(negedge clk);
      check(perr_n, exp_q, "R3 random last");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule